// File: doc/BRIEF.md
# Prioritized CPU Interrupt Controller

This block gathers sixteen peripheral interrupt sources and steers them onto twelve maskable CPU request lines, numbered 4 to 15. A programmable 5-bit selector per line chooses which source drives it. Two further requests, a reset request and a nonmaskable request, enter directly. A rising edge on any routed line or on either direct request makes that request pending. Among all pending requests a fixed priority picks one. The block tells the CPU whether that request may be taken now, gives its number, and gives the address of its 32-byte service packet.

Software programs the block through a synchronous 32-bit register port with a 3-bit index. Writes take effect on the clock edge. Reads are combinational from the index. Through this port software sets a global enable, sets the per-line enables and the nonmaskable enable, sets or clears pending bits, moves the service table base, and chooses the routing. When the CPU starts servicing the offered request it raises `ack`. The block then drops that request's pending bit. For a maskable request it also drops the global enable, so that the service routine is not interrupted by another maskable request.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset there is no request (`irq_valid`=0), and reads return: index 0 = 0, index 1 = 0x1, index 2 = 0, index 5 = 0. Indices 6 and 7 hold the default routing, in which line k selects source k-4.
- R2: A 0-to-1 transition on the source routed to line k sets pending bit k, visible one clock later. A source held high does not set the bit again after it has been cleared.
- R3: Line k has a 5-bit selector field at bits [5*(k-4)+4 : 5*(k-4)] of index 6 for k = 4..9, and at bits [5*(k-10)+4 : 5*(k-10)] of index 7 for k = 10..15. A field value of 0 to 15 selects that source. A value of 16 to 31 leaves the line at 0.
- R4: Writing index 3 sets the pending bits that are written as 1. Writing index 4 clears them. Both act only on bits 4 to 15 and ignore bits 0 to 3. If an edge sets a bit in the same cycle as a clear write to that bit, the edge wins and the bit stays set.
- R5: A maskable request k is offered only when all of these hold: the global enable (index 0 bit 0) is 1, the nonmaskable enable (index 1 bit 1) is 1, the line enable (index 1 bit k) is 1, and pending bit k is set.
- R6: The priority order is reset (0), then nonmaskable (1), then 4, 5, ..., 15. Only the highest-priority pending request is considered. If that request is maskable but not enabled, lower-priority requests are blocked.
- R7: A pending nonmaskable request (pending bit 1, set by a rising edge of `nmi_req`) is offered as number 1 whatever the global enable and the enable register hold.
- R8: For request 0 the vector is 0. For any other request it is {base[31:9], number, 5'b0}. Base is written at index 5, where only bits 31..9 are stored and bits 8..0 read as 0.
- R9: `ack` while a request is offered clears that request's pending bit. If the request is maskable, `ack` also clears the global enable, and this takes precedence over a write to index 0 in the same cycle.
- R10: At index 1, bit 0 reads 1 and bits 2 and 3 read 0. Index 2 shows the pending bits and ignores writes. Indices 3 and 4 read as 0.
- R11: A rising edge of `rst_req` sets pending bit 0. That request is offered as number 0 with no enable needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | 16 | Peripheral interrupt sources |
| rst_req | input | 1 | Reset request |
| nmi_req | input | 1 | Nonmaskable request |
| reg_wen | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| ack | input | 1 | CPU takes the offered request |
| irq_valid | output | 1 | A request is offered |
| irq_num | output | 4 | Number of the offered request |
| irq_vector | output | 32 | Service packet address |

## Verification
Two pairs of events can collide in one cycle. A routed source edge can arrive together with a software clear of the same pending bit. An acknowledge of a maskable request can arrive together with a write that sets the global enable. The bench drives each pair on the same clock edge. It then reads back through the port that the pending bit survived the clear, and that the global enable ended up 0 with the other pending request still held but not offered. A vector table then sweeps the enable combinations and priority blocking.

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl #(
  parameter int NUM_SRC = 16,
  parameter int VEC_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic             rst_req,
  input  logic             nmi_req,
  input  logic             reg_wen,
  input  logic [2:0]       reg_idx,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             ack,
  output logic             irq_valid,
  output logic [3:0]       irq_num,
  output logic [VEC_W-1:0] irq_vector
);
  localparam int LINES   = 16;
  localparam int SEL_W   = 5;
  localparam int FIELDS  = 6;
  localparam int MUX_W   = SEL_W * FIELDS;
  localparam int PKT_LSB = 5;
  localparam int BASE_LSB = PKT_LSB + 4;
  localparam logic [LINES-1:0] SW_MASK   = 16'hFFF0;
  localparam logic [LINES-1:0] EDGE_MASK = 16'hFFF3;
  localparam logic [LINES-1:0] IER_MASK  = 16'hFFF2;

  function automatic logic [MUX_W-1:0] mux_init(input int first);
    logic [MUX_W-1:0] v;
    v = '0;
    for (int i = 0; i < FIELDS; i++) v[SEL_W*i +: SEL_W] = SEL_W'(first + i);
    return v;
  endfunction

  logic                  gie;
  logic [LINES-1:0]      ier_q;
  logic [LINES-1:0]      flag_q;
  logic [VEC_W-1:BASE_LSB] base_q;
  logic [MUX_W-1:0]      mux_lo, mux_hi;
  logic [LINES-1:0]      line, line_q, rise;
  logic [31:0]           src_pad;
  logic [3:0]            top;
  logic                  has_pend, nonmask, ack_take;
  logic [LINES-1:0]      sw_set, sw_clr, ack_clr, flag_d;

  assign src_pad = 32'(src_irq);
  assign line[0] = rst_req;
  assign line[1] = nmi_req;
  assign line[3:2] = 2'b00;

  for (genvar k = 4; k < LINES; k++) begin : g_route
    logic [SEL_W-1:0] fld;
    if (k < 4 + FIELDS) begin : g_lo
      assign fld = mux_lo[SEL_W*(k-4) +: SEL_W];
    end else begin : g_hi
      assign fld = mux_hi[SEL_W*(k-4-FIELDS) +: SEL_W];
    end
    assign line[k] = src_pad[fld];
  end

  assign rise = line & ~line_q & EDGE_MASK;

  always_comb begin
    top = 4'd0;
    has_pend = 1'b0;
    for (int i = LINES-1; i >= 0; i--)
      if (flag_q[i]) begin
        top = 4'(i);
        has_pend = 1'b1;
      end
  end

  assign nonmask   = top < 4'd2;
  assign irq_valid = has_pend && (nonmask || (gie && ier_q[1] && ier_q[top]));
  assign irq_num   = top;
  assign irq_vector = (top == 4'd0) ? '0 : {base_q, top, {PKT_LSB{1'b0}}};

  assign ack_take = ack && irq_valid;
  assign ack_clr  = ack_take ? (16'd1 << top) : '0;
  assign sw_set   = (reg_wen && reg_idx == 3'd3) ? (reg_wdata[15:0] & SW_MASK) : '0;
  assign sw_clr   = (reg_wen && reg_idx == 3'd4) ? (reg_wdata[15:0] & SW_MASK) : '0;
  assign flag_d   = (flag_q & ~(sw_clr | ack_clr)) | sw_set | rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie    <= 1'b0;
      ier_q  <= '0;
      flag_q <= '0;
      base_q <= '0;
      mux_lo <= mux_init(0);
      mux_hi <= mux_init(FIELDS);
      line_q <= '0;
    end else begin
      line_q <= line;
      flag_q <= flag_d;
      if (ack_take && !nonmask) gie <= 1'b0;
      else if (reg_wen && reg_idx == 3'd0) gie <= reg_wdata[0];
      if (reg_wen && reg_idx == 3'd1) ier_q <= reg_wdata[15:0] & IER_MASK;
      if (reg_wen && reg_idx == 3'd5) base_q <= reg_wdata[VEC_W-1:BASE_LSB];
      if (reg_wen && reg_idx == 3'd6) mux_lo <= reg_wdata[MUX_W-1:0];
      if (reg_wen && reg_idx == 3'd7) mux_hi <= reg_wdata[MUX_W-1:0];
    end
  end

  always_comb begin
    case (reg_idx)
      3'd0:    reg_rdata = {31'd0, gie};
      3'd1:    reg_rdata = {16'd0, ier_q | 16'd1};
      3'd2:    reg_rdata = {16'd0, flag_q};
      3'd5:    reg_rdata = 32'({base_q, {BASE_LSB{1'b0}}});
      3'd6:    reg_rdata = 32'(mux_lo);
      3'd7:    reg_rdata = 32'(mux_hi);
      default: reg_rdata = 32'd0;
    endcase
  end

  // R2
  edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((flag_q & $past(rise)) == $past(rise)));

  // R4
  set_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_idx == 3'd3) |=>
      ((flag_q & ($past(reg_wdata[15:0]) & SW_MASK)) == ($past(reg_wdata[15:0]) & SW_MASK)));

  // R5
  maskable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_num >= 4'd4) |-> (gie && ier_q[1] && ier_q[irq_num]));

  // R6
  highest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((flag_q & ((16'd1 << irq_num) - 16'd1)) == '0));

  // R8
  vector_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector[PKT_LSB-1:0] == '0 && (irq_num != 4'd0 || irq_vector == '0)));

  // R9
  ack_drops_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_valid && irq_num >= 4'd4) |=> !gie);

  // R11
  reset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q[0] |-> (irq_valid && irq_num == 4'd0));
endmodule

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;
  logic        clk = 0, rst_n = 0;
  logic [15:0] src_irq = 0;
  logic        rst_req = 0, nmi_req = 0, reg_wen = 0, ack = 0;
  logic [2:0]  reg_idx = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, irq_vector, rv;
  logic        irq_valid;
  logic [3:0]  irq_num;
  int checks = 0, errors = 0;

  irq_prio_ctrl uut (.clk(clk), .rst_n(rst_n), .src_irq(src_irq), .rst_req(rst_req),
    .nmi_req(nmi_req), .reg_wen(reg_wen), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ack(ack), .irq_valid(irq_valid), .irq_num(irq_num),
    .irq_vector(irq_vector));

  always #4 clk = ~clk;

  // {gie, enable[15:0], set[15:0], exp_valid, exp_num}
  localparam logic [37:0] VEC [0:7] = '{
    {1'b1, 16'h0012, 16'h0010, 1'b1, 4'd4},
    {1'b0, 16'h0012, 16'h0010, 1'b0, 4'd0},
    {1'b1, 16'h0010, 16'h0010, 1'b0, 4'd0},
    {1'b1, 16'h0002, 16'h0010, 1'b0, 4'd0},
    {1'b1, 16'hFFF2, 16'h8200, 1'b1, 4'd9},
    {1'b1, 16'h8002, 16'h8200, 1'b0, 4'd0},
    {1'b1, 16'hFFF2, 16'h8000, 1'b1, 4'd15},
    {1'b1, 16'hFFF2, 16'h000F, 1'b0, 4'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk); reg_wen = 1; reg_idx = i; reg_wdata = d;
    @(negedge clk); reg_wen = 0;
  endtask

  task automatic rd(input logic [2:0] i, output logic [31:0] d);
    @(negedge clk); reg_idx = i; #1; d = reg_rdata;
  endtask

  task automatic pulse_src(input logic [15:0] m);
    @(negedge clk); src_irq = m;
    @(negedge clk); src_irq = 0;
  endtask

  task automatic do_ack;
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  function automatic logic [31:0] mux_def(input int first);
    logic [31:0] v = 0;
    for (int i = 0; i < 6; i++) v |= 32'(first + i) << (5 * i);
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lo, hi;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    check("R1 valid", 32'(irq_valid), 0);
    rd(1, rv); check("R1 enable", rv, 32'h1);
    rd(0, rv); check("R1 control", rv, 0);
    rd(2, rv); check("R1 flags", rv, 0);
    rd(5, rv); check("R1 base", rv, 0);
    rd(6, rv); check("R1 mux low", rv, mux_def(0));
    rd(7, rv); check("R1 mux high", rv, mux_def(6));

    for (int n = 0; n < 8; n++) begin
      wr(4, 32'hFFFF);
      wr(0, 32'(VEC[n][37]));
      wr(1, 32'(VEC[n][36:21]));
      wr(3, 32'(VEC[n][20:5]));
      check($sformatf("R5 R6 table %0d valid", n), 32'(irq_valid), 32'(VEC[n][4]));
      if (VEC[n][4]) begin
        check($sformatf("R6 table %0d num", n), 32'(irq_num), 32'(VEC[n][3:0]));
        check($sformatf("R8 table %0d vector", n), irq_vector, 32'(VEC[n][3:0]) << 5);
      end
    end
    rd(2, rv); check("R4 low bits ignored", rv, 0);

    wr(1, 32'hFFFF); rd(1, rv); check("R10 enable read", rv, 32'hFFF3);
    wr(2, 32'hFFFF); rd(2, rv); check("R10 flag read-only", rv, 0);
    rd(3, rv); check("R10 set reads 0", rv, 0);
    rd(4, rv); check("R10 clear reads 0", rv, 0);

    wr(0, 0);
    @(negedge clk); src_irq = 16'h0004;
    rd(2, rv); check("R2 edge sets flag", rv, 32'h0040);
    wr(4, 32'h0040);
    rd(2, rv); check("R2 level no retrigger", rv, 0);
    @(negedge clk); src_irq = 0;

    lo = mux_def(0); lo[4:0] = 5'd7; lo[9:5] = 5'd16;
    wr(6, lo);
    pulse_src(16'h0080);
    rd(2, rv); check("R3 rerouted line", rv, 32'h0810);
    wr(4, 32'hFFFF);
    @(negedge clk); src_irq = 16'hFFFF;
    rd(2, rv); check("R3 field 16 disconnects", rv, 32'hFFD0);
    @(negedge clk); src_irq = 0;
    wr(4, 32'hFFFF);
    hi = mux_def(6); hi[29:25] = 5'd3;
    wr(7, hi);
    pulse_src(16'h0008);
    rd(2, rv); check("R3 high field", rv, 32'h8080);
    wr(4, 32'hFFFF);

    @(negedge clk); src_irq = 16'h0080; reg_wen = 1; reg_idx = 4; reg_wdata = 32'h0010;
    @(negedge clk); reg_wen = 0;
    rd(2, rv); check("R4 edge beats clear", rv, 32'h0810);
    @(negedge clk); src_irq = 0;
    wr(4, 32'hFFFF);
    wr(6, mux_def(0)); wr(7, mux_def(6));

    wr(0, 0); wr(1, 0);
    @(negedge clk); nmi_req = 1;
    @(negedge clk); nmi_req = 0;
    check("R7 nmi valid", 32'(irq_valid), 1);
    check("R7 nmi num", 32'(irq_num), 1);
    check("R8 nmi vector", irq_vector, 32'h20);
    do_ack;
    check("R9 ack clears nmi", 32'(irq_valid), 0);
    rd(2, rv); check("R9 nmi flag gone", rv, 0);

    wr(5, 32'h12345678);
    rd(5, rv); check("R8 base read", rv, 32'h12345600);
    wr(0, 1); wr(1, 32'hFFFF); wr(3, 32'h0200);
    check("R8 int9 num", 32'(irq_num), 9);
    check("R8 relocated vector", irq_vector, 32'h12345720);

    @(negedge clk); rst_req = 1; nmi_req = 1;
    @(negedge clk); rst_req = 0; nmi_req = 0;
    check("R11 reset num", 32'(irq_num), 0);
    check("R11 reset vector", irq_vector, 0);
    do_ack;
    check("R6 nmi after reset", 32'(irq_num), 1);
    check("R8 nmi relocated", irq_vector, 32'h12345620);
    do_ack;
    check("R6 int9 after nmi", {31'd0, irq_valid} << 4 | 32'(irq_num), 32'h19);

    wr(3, 32'h1000);
    @(negedge clk); ack = 1; reg_wen = 1; reg_idx = 0; reg_wdata = 1;
    @(negedge clk); ack = 0; reg_wen = 0;
    check("R9 gie off blocks", 32'(irq_valid), 0);
    rd(0, rv); check("R9 ack beats control write", rv, 0);
    rd(2, rv); check("R9 only taken flag cleared", rv, 32'h1000);
    wr(0, 1);
    check("R9 next request num", 32'(irq_num), 12);
    check("R8 int12 vector", irq_vector, 32'h12345780);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule